// File: doc/BRIEF.md
# Card-Area Strobe Timing Generator

This block sequences the control strobes for one external memory area that holds card-style peripherals. A request carries an address, a read/write flag and per-lane byte enables. It is shaped by a programmed wait count, a setup setting, a hold setting and a burst enable. The block drives the active-low lane card enables, the active-low read and write strobes, the access address and a one-cycle done pulse.

The sequencer runs on a clock at twice the bus rate, so one tick of that clock is half a bus cycle. Every phase boundary therefore lands on a half-cycle edge. A transfer moves through setup, strobe, an optional wait extension and hold. A slow card can stretch the strobe with the external wait input. In burst mode a fixed number of beats is issued, with the beat spacing set by the wait setting.

Top module: `cst_card_strobe_gen`

## Requirements
- R1: After reset and whenever idle, all card enables, `rd_n` and `wr_n` are 1, `done` is 0 and `req_ready` is 1.
- R2: Card enables fall in the tick after a request is accepted. The first strobe falls 2*S+1 ticks later, where S is the 2-bit `cfg_setup` code.
- R3: After the last strobe rises, card enables stay low for 2*H+1 ticks, where H is the 2-bit `cfg_hold` code.
- R4: In a single transfer with no external wait, the strobe is low for 2*(1+W) ticks, where W is the effective wait count.
- R5: The effective wait count W is the 4-bit `cfg_wait` code for codes 0 to 10. Codes 11 to 15 act as 10.
- R6: `ext_wait` is sampled only in the last tick of a strobe. Each sample at 1 extends that strobe by 2 ticks, and the strobe rises only after a sample at 0.
- R7: A read drives `rd_n` low and all card enables low. A write drives `wr_n` low, and bit i of `card_en_n` is low exactly when bit i of `req_be` is 1.
- R8: With `cfg_burst`=1, BURST_BEATS strobes are issued. Let P = max(2, W). Strobe falls are 2*P ticks apart, each strobe is low for 2*P-1 ticks, and the address advances by LANES per beat.
- R9: `done` is high for exactly one tick, in the first tick after hold, with card enables high. A request presented while busy is ignored.
- R10: `rd_n` and `wr_n` are never low in the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this tick |
| req_addr | input | ADDR_W | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | LANES | Byte-lane enables for writes |
| cfg_wait | input | WAIT_W | Programmed wait count code |
| cfg_setup | input | 2 | Setup code, (2*code+1) half cycles |
| cfg_hold | input | 2 | Hold code, (2*code+1) half cycles |
| cfg_burst | input | 1 | Burst enable |
| ext_wait | input | 1 | External wait, active high |
| card_addr | output | ADDR_W | Address of the current beat |
| card_en_n | output | LANES | Active-low card enables per lane |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-tick completion pulse |

## Verification
The end of the programmed wait and a high external wait sample can meet in the same tick. The strobe then has to choose between extending and moving into hold or the next beat. The bench provokes this by holding `ext_wait` high for a counted number of strobe ticks, so that the sample lands before, at or after the last programmed tick. It then compares the measured strobe width with the width predicted by R6. A request pulsed in the middle of a transfer, landing in the same tick as strobe activity, is judged by checking that no second transfer starts after `done`.

// File: rtl/cst_pkg.sv
package cst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_GAP    = 3'd3,
      ST_HOLD   = 3'd4,
      ST_DONE   = 3'd5
   } cst_state_e;

   // reload value for a phase lasting (2*code+1) half cycles
   function automatic int unsigned half_reload(input int unsigned code);
      return 2 * code;
   endfunction
endpackage

// File: rtl/cst_cfg_decode.sv
module cst_cfg_decode #(
   parameter int WAIT_W   = 4,
   parameter int MAX_WAIT = 10,
   parameter int CNT_W    = 5
) (
   input  logic [WAIT_W-1:0] wait_code,
   input  logic [1:0]        setup_code,
   input  logic [1:0]        hold_code,
   input  logic              burst,
   output logic [CNT_W-1:0]  setup_reload,
   output logic [CNT_W-1:0]  strobe_reload,
   output logic [CNT_W-1:0]  hold_reload
);
   import cst_pkg::*;
   localparam int CODE_MAX = (1 << WAIT_W) - 1;

   logic [WAIT_W-1:0] w_eff;

   generate
      if (CODE_MAX > MAX_WAIT) begin : g_clamp
         always_comb
            w_eff = (int'(wait_code) > MAX_WAIT) ? WAIT_W'(MAX_WAIT) : wait_code;
      end else begin : g_pass
         always_comb w_eff = wait_code;
      end
   endgenerate

   int unsigned pitch;
   always_comb begin
      pitch         = (int'(w_eff) < 2) ? 2 : int'(w_eff);
      setup_reload  = CNT_W'(half_reload(int'(setup_code)));
      hold_reload   = CNT_W'(half_reload(int'(hold_code)));
      if (burst) strobe_reload = CNT_W'(2 * pitch - 2);
      else       strobe_reload = CNT_W'(2 * int'(w_eff) + 1);
   end
endmodule

// File: rtl/cst_phase_timer.sv
module cst_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             at_last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign at_last = (cnt_q == '0);
endmodule

// File: rtl/cst_lane_enables.sv
module cst_lane_enables #(
   parameter int LANES = 2
) (
   input  logic             active,
   input  logic             is_write,
   input  logic [LANES-1:0] be,
   output logic [LANES-1:0] en_n
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign en_n[i] = ~(active & (~is_write | be[i]));
      end
   endgenerate
endmodule

// File: rtl/cst_card_strobe_gen.sv
module cst_card_strobe_gen #(
   parameter int ADDR_W      = 16,
   parameter int LANES       = 2,
   parameter int WAIT_W      = 4,
   parameter int MAX_WAIT    = 10,
   parameter int BURST_BEATS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_be,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic [1:0]        cfg_setup,
   input  logic [1:0]        cfg_hold,
   input  logic              cfg_burst,
   input  logic              ext_wait,
   output logic [ADDR_W-1:0] card_addr,
   output logic [LANES-1:0]  card_en_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              done
);
   import cst_pkg::*;

   localparam int CNT_W  = $clog2(2 * MAX_WAIT + 3);
   localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

   initial begin
      assert (MAX_WAIT >= 2 && MAX_WAIT < (1 << WAIT_W) + 1)
         else $error("MAX_WAIT out of range for WAIT_W");
      assert (LANES >= 1 && BURST_BEATS >= 1)
         else $error("LANES and BURST_BEATS must be positive");
   end

   cst_state_e         state_q, state_d;
   logic [CNT_W-1:0]   setup_rl, strobe_rl, hold_rl;
   logic [CNT_W-1:0]   strobe_rl_q, hold_rl_q, load_val;
   logic               load, at_last, accept;
   logic               write_q, burst_q;
   logic [LANES-1:0]   be_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [BEAT_W-1:0]  beats_left_q;

   cst_cfg_decode #(.WAIT_W(WAIT_W), .MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_dec (
      .wait_code     (cfg_wait),
      .setup_code    (cfg_setup),
      .hold_code     (cfg_hold),
      .burst         (cfg_burst),
      .setup_reload  (setup_rl),
      .strobe_reload (strobe_rl),
      .hold_reload   (hold_rl)
   );

   cst_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .at_last  (at_last)
   );

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            state_d = ST_SETUP; load = 1'b1; load_val = setup_rl;
         end
         ST_SETUP: if (at_last) begin
            state_d = ST_STROBE; load = 1'b1; load_val = strobe_rl_q;
         end
         ST_STROBE: if (at_last) begin
            load = 1'b1;
            if (ext_wait) begin
               load_val = CNT_W'(1);
            end else if (burst_q && beats_left_q != '0) begin
               state_d = ST_GAP;
            end else begin
               state_d = ST_HOLD; load_val = hold_rl_q;
            end
         end
         ST_GAP: begin
            state_d = ST_STROBE; load = 1'b1; load_val = strobe_rl_q;
         end
         ST_HOLD: if (at_last) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         write_q      <= 1'b0;
         burst_q      <= 1'b0;
         be_q         <= '0;
         addr_q       <= '0;
         beats_left_q <= '0;
         strobe_rl_q  <= '0;
         hold_rl_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            write_q      <= req_write;
            burst_q      <= cfg_burst;
            be_q         <= req_be;
            addr_q       <= req_addr;
            beats_left_q <= cfg_burst ? BEAT_W'(BURST_BEATS - 1) : '0;
            strobe_rl_q  <= strobe_rl;
            hold_rl_q    <= hold_rl;
         end else if (state_q == ST_GAP) begin
            addr_q       <= addr_q + ADDR_W'(LANES);
            beats_left_q <= beats_left_q - 1'b1;
         end
      end
   end

   logic card_active, strobing;
   assign card_active = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                        (state_q == ST_GAP)   || (state_q == ST_HOLD);
   assign strobing    = (state_q == ST_STROBE);

   cst_lane_enables #(.LANES(LANES)) u_lanes (
      .active   (card_active),
      .is_write (write_q),
      .be       (be_q),
      .en_n     (card_en_n)
   );

   assign rd_n      = ~(strobing & ~write_q);
   assign wr_n      = ~(strobing &  write_q);
   assign done      = (state_q == ST_DONE);
   assign req_ready = (state_q == ST_IDLE);
   assign card_addr = addr_q;
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] card_en_n,
   input logic             rd_n,
   input logic             wr_n,
   input logic             done,
   input logic             req_ready,
   input logic             ext_wait
);
   logic strb, card_on;
   assign strb    = ~rd_n | ~wr_n;
   assign card_on = ~&card_en_n;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!card_on && rd_n && wr_n && !done));

   p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb) |-> $past(card_on));

   p_hold_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb) |-> card_on);

   p_wait_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb) |-> !$past(ext_wait));

   p_strobe_card_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> card_on);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
endmodule

bind cst_card_strobe_gen cst_checker #(.LANES(LANES)) u_cst_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .card_en_n (card_en_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .done      (done),
   .req_ready (req_ready),
   .ext_wait  (ext_wait)
);

// File: tb/test_cst_card_strobe_gen.sv
`timescale 1ns/1ps
module test_cst_card_strobe_gen;
   localparam int ADDR_W = 16, LANES = 2, WAIT_W = 4, BEATS = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_ready, req_write = 0, cfg_burst = 0, ext_wait = 0;
   logic [ADDR_W-1:0] req_addr = '0, card_addr;
   logic [LANES-1:0]  req_be = '0, card_en_n;
   logic [WAIT_W-1:0] cfg_wait = '0;
   logic [1:0] cfg_setup = '0, cfg_hold = '0;
   logic rd_n, wr_n, done;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cst_card_strobe_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .WAIT_W(WAIT_W),
                         .MAX_WAIT(10), .BURST_BEATS(BEATS)) i_cst_card_strobe_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
      .cfg_wait(cfg_wait), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
      .cfg_burst(cfg_burst), .ext_wait(ext_wait), .card_addr(card_addr),
      .card_en_n(card_en_n), .rd_n(rd_n), .wr_n(wr_n), .done(done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // {wr, be[1:0], wait[3:0], setup[1:0], hold[1:0], burst, xw[2:0]}
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 2'b11, 4'd0,  2'd0, 2'd0, 1'b0, 3'd0},
      {1'b1, 2'b01, 4'd3,  2'd1, 2'd2, 1'b0, 3'd0},
      {1'b1, 2'b10, 4'd10, 2'd3, 2'd3, 1'b0, 3'd0},
      {1'b0, 2'b00, 4'd13, 2'd0, 2'd1, 1'b0, 3'd0},
      {1'b0, 2'b11, 4'd2,  2'd2, 2'd0, 1'b0, 3'd7},
      {1'b1, 2'b11, 4'd0,  2'd0, 2'd1, 1'b0, 3'd1},
      {1'b0, 2'b11, 4'd0,  2'd1, 2'd1, 1'b1, 3'd0},
      {1'b1, 2'b11, 4'd6,  2'd0, 2'd2, 1'b1, 3'd0},
      {1'b0, 2'b01, 4'd15, 2'd1, 2'd0, 1'b1, 3'd0},
      {1'b0, 2'b11, 4'd1,  2'd0, 2'd0, 1'b0, 3'd4}
   };

   task automatic run_xfer(input logic wr, input logic [1:0] be, input int w,
                           input int s, input int h, input logic burst,
                           input int xw, input logic [15:0] base);
      int weff, pitch, exp_len, nruns, t_ce0, t_end, t_done, both, bad_ce, bad_dir;
      int run_start[8], run_len[8], addr_at[8];
      bit prev_st, st, cel, ce_at_done;
      logic [1:0] exp_ce;
      weff  = (w > 10) ? 10 : w;
      pitch = (weff < 2) ? 2 : weff;
      exp_ce = wr ? ~be : 2'b00;
      @(negedge clk);
      req_addr = base; req_write = wr; req_be = be; cfg_wait = WAIT_W'(w);
      cfg_setup = 2'(s); cfg_hold = 2'(h); cfg_burst = burst; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      nruns = 0; t_ce0 = -1; t_end = -1; t_done = -1; both = 0; bad_ce = 0;
      bad_dir = 0; prev_st = 0; ce_at_done = 0;
      for (int t = 0; t < 600; t++) begin
         st  = !rd_n || !wr_n;
         cel = ~&card_en_n;
         if (cel && t_ce0 < 0) t_ce0 = t;
         if (st && !prev_st) begin
            if (nruns < 8) begin
               run_start[nruns] = t; run_len[nruns] = 0; addr_at[nruns] = int'(card_addr);
            end
            nruns++;
         end
         if (st && nruns <= 8) run_len[nruns-1]++;
         if (!st && prev_st) t_end = t;
         if (st && card_en_n != exp_ce) bad_ce++;
         if (st && (wr ? (wr_n || !rd_n) : (rd_n || !wr_n))) bad_dir++;
         if (!rd_n && !wr_n) both++;
         ext_wait = (nruns == 1 && st) ? (run_len[0] <= xw) : 1'b0;
         prev_st = st;
         if (done) begin t_done = t; ce_at_done = !cel; break; end
         @(negedge clk);
      end
      ext_wait = 0;
      chk(t_ce0 == 0, "R2 enable start", t_ce0, 0);
      chk(nruns >= 1 && run_start[0] - t_ce0 == 2*s+1, "R2 setup", run_start[0]-t_ce0, 2*s+1);
      if (!burst) begin
         exp_len = 2*(1+weff);
         while (exp_len - 1 < xw) exp_len += 2;
         chk(run_len[0] == exp_len, (xw > 0) ? "R6 ext wait width" :
             (w > 10) ? "R5 clamp width" : "R4 strobe width", run_len[0], exp_len);
         chk(nruns == 1, "R8 single beat", nruns, 1);
      end else begin
         chk(nruns == BEATS, "R8 beat count", nruns, BEATS);
         for (int k = 0; k < BEATS && k < nruns; k++) begin
            chk(run_len[k] == 2*pitch-1, "R8 beat width", run_len[k], 2*pitch-1);
            chk(addr_at[k] == int'(base) + k*LANES, "R8 beat address", addr_at[k], int'(base)+k*LANES);
            if (k > 0)
               chk(run_start[k]-run_start[k-1] == 2*pitch, "R8 pitch",
                   run_start[k]-run_start[k-1], 2*pitch);
         end
      end
      chk(t_done - t_end == 2*h+1, "R3 hold", t_done - t_end, 2*h+1);
      chk(ce_at_done, "R9 done with enables released", ce_at_done, 1);
      chk(bad_ce == 0, "R7 lane enables", bad_ce, 0);
      chk(bad_dir == 0, "R7 strobe direction", bad_dir, 0);
      chk(both == 0, "R10 exclusive strobes", both, 0);
      chk(addr_at[0] == int'(base), "R7 address", addr_at[0], int'(base));
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(&card_en_n && rd_n && wr_n && !done, "R1 in reset", {card_en_n, rd_n, wr_n, done}, 5'b11110);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(req_ready && &card_en_n && rd_n && wr_n && !done, "R1 idle after reset",
          {req_ready, card_en_n, rd_n, wr_n, done}, 6'b111110);

      for (int v = 0; v < NV; v++)
         run_xfer(VEC[v][14], VEC[v][13:12], int'(VEC[v][11:8]), int'(VEC[v][7:6]),
                  int'(VEC[v][5:4]), VEC[v][3], int'(VEC[v][2:0]), 16'(16'h0100 + v*16'h40));

      // R9: request presented while busy must not start a new transfer
      @(negedge clk);
      req_addr = 16'h0800; req_write = 0; cfg_wait = 4'd4; cfg_setup = 2'd1;
      cfg_hold = 2'd1; cfg_burst = 0; req_valid = 1;
      @(negedge clk); req_valid = 0;
      repeat (4) @(negedge clk);
      chk(!req_ready, "R9 busy not ready", req_ready, 0);
      req_addr = 16'h0900; req_valid = 1;
      @(negedge clk); req_valid = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(req_ready, "R9 ready after done", req_ready, 1);
      repeat (6) @(negedge clk);
      chk(&card_en_n && rd_n && req_ready, "R9 busy request ignored",
          {card_en_n, rd_n, req_ready}, 4'b1111);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule